// File: doc/BRIEF.md
# Paced JTAG Pair Shifter with Capture

This block drives a serial test-access chain from a stream of packed bytes. Each byte carries four pairs of test-mode-select (TMS) and test-data-in (TDI) values. For each pair the block places the values on the pins while the test clock (TCK) is low and then raises TCK. The speed of the waveform is set by a delay value that lengthens every TCK phase. When a request asks for capture, the block samples test-data-out (TDO) at each rising TCK edge. It packs those bits into bytes and hands each byte out with a one-clock valid pulse.

There are eight chain ports. A request latches a chain number, and only that chain is driven and sampled. The other chains hold TCK at its idle level and keep their last TMS and TDI. A three-bit polarity mask can invert the TCK, TMS and TDI pins on every chain, so the pins can drive level converters that invert. A controller starts a request with the pair count, capture flag, chain and delay. It supplies payload bytes through a valid/ready pair and waits for the done pulse before it starts the next request.

Top module: `jtag_pair_shifter`

## Requirements
- R1: Payload byte bits [2k+1] (TMS) and [2k] (TDI) form pair k, for k = 0..3. Pair 0 is shifted first. A byte is taken when `in_valid` and `in_ready` are both high at a clock edge, and a request of n pairs takes exactly ceil(n/4) bytes. The pair on the pins at each rising TCK edge is the next pair of the request.
- R2: TMS and TDI of the selected chain never change while its TCK is high. Each bit is a low TCK phase followed by a high phase, and TCK is low again at the end of every bit.
- R3: With a delay value D, each high TCK phase lasts exactly D+1 clocks and each low phase lasts at least D+1 clocks. Between pairs of the same byte the low phase lasts exactly D+1 clocks.
- R4: Only the chain given by `chain_sel` at start receives TCK pulses and new TMS/TDI values. On every other chain all pins stay unchanged, and TDO of an unselected chain never affects the captured data.
- R5: `invert[0]`, `invert[1]` and `invert[2]` invert TCK, TMS and TDI on every chain, including at idle. The logical idle level of TCK is 0.
- R6: With capture requested, the TDO of the selected chain is sampled in the clock where TCK rises. Captured bit j goes to bit j mod 8 of output byte j div 8. Each byte appears on `out_data` for one clock with `out_valid` high.
- R7: A final partial byte of captured data is still emitted, with its unused upper bits zero.
- R8: Without capture, `out_valid` never rises during the request.
- R9: `done` pulses for one clock in the clock where the last TCK high phase ends. `busy` is high from the clock after a start is accepted until that clock. A `start` while busy is ignored.
- R10: A request with a pair count of 0 takes no byte, makes no TCK pulse and raises `done` in the clock after the start.
- R11: After reset the block is idle, every logical TCK/TMS/TDI is 0, and `in_ready`, `out_valid`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request start, taken while idle |
| pair_count | input | LENW | Number of TMS/TDI pairs to shift |
| capture | input | 1 | Capture TDO during the request |
| chain_sel | input | $clog2(NCHAINS) | Chain to drive |
| tck_delay | input | DLYW | Extra clocks added to every TCK phase |
| invert | input | 3 | Pin inversion: bit 0 TCK, bit 1 TMS, bit 2 TDI |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte of four pairs |
| in_ready | output | 1 | Block takes a payload byte |
| out_valid | output | 1 | Captured byte valid for one clock |
| out_data | output | 8 | Captured TDO byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock pulse at request end |
| tck_o | output | NCHAINS | TCK per chain |
| tms_o | output | NCHAINS | TMS per chain |
| tdi_o | output | NCHAINS | TDI per chain |
| tdo_i | input | NCHAINS | TDO per chain |

## Verification
The bench builds the block with its default parameters: eight chains, a 12-bit pair count and a 16-bit delay. With these values every chain number can be selected, and a request of the full 4095 pairs can run in one go. That request ends with a partial capture byte and takes 1024 payload bytes. Delays from 0 to 5 are used, so phase lengths are checked at and just above the one-clock minimum.

// File: rtl/jtag_pair_shifter.sv
module jtag_pair_shifter #(
  parameter int NCHAINS = 8,
  parameter int LENW = 12,
  parameter int DLYW = 16,
  localparam int CHW = $clog2(NCHAINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LENW-1:0]    pair_count,
  input  logic               capture,
  input  logic [CHW-1:0]     chain_sel,
  input  logic [DLYW-1:0]    tck_delay,
  input  logic [2:0]         invert,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [7:0]         out_data,
  output logic               busy,
  output logic               done,
  output logic [NCHAINS-1:0] tck_o,
  output logic [NCHAINS-1:0] tms_o,
  output logic [NCHAINS-1:0] tdi_o,
  input  logic [NCHAINS-1:0] tdo_i
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOW, S_HIGH} st_t;

  st_t               st;
  logic [LENW-1:0]   left;
  logic [DLYW-1:0]   dly_q, cnt;
  logic [CHW-1:0]    sel_q;
  logic              cap_q;
  logic [7:0]        shreg;
  logic [1:0]        pidx;
  logic [NCHAINS-1:0] tms_q, tdi_q, tck_l;
  logic [7:0]        acc;
  logic [2:0]        bcnt;

  wire       tdo_sel = tdo_i[sel_q];
  wire [1:0] nxt = pidx + 2'd1;
  wire [7:0] acc_nx = acc | ({7'd0, tdo_sel} << bcnt);

  assign in_ready = (st == S_FETCH);
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      left <= '0;
      dly_q <= '0;
      cnt <= '0;
      sel_q <= '0;
      cap_q <= 1'b0;
      shreg <= '0;
      pidx <= '0;
      tms_q <= '0;
      tdi_q <= '0;
      acc <= '0;
      bcnt <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sel_q <= chain_sel;
          dly_q <= tck_delay;
          cap_q <= capture;
          left <= pair_count;
          acc <= '0;
          bcnt <= '0;
          if (pair_count == '0) done <= 1'b1;
          else st <= S_FETCH;
        end
        S_FETCH: if (in_valid) begin
          shreg <= in_data;
          pidx <= '0;
          tms_q[sel_q] <= in_data[1];
          tdi_q[sel_q] <= in_data[0];
          cnt <= dly_q;
          st <= S_LOW;
        end
        S_LOW: if (cnt == '0) begin
          st <= S_HIGH;
          cnt <= dly_q;
          if (cap_q) begin
            if (bcnt == 3'd7 || left == LENW'(1)) begin
              out_data <= acc_nx;
              out_valid <= 1'b1;
              acc <= '0;
              bcnt <= '0;
            end else begin
              acc <= acc_nx;
              bcnt <= bcnt + 3'd1;
            end
          end
        end else cnt <= cnt - DLYW'(1);
        S_HIGH: if (cnt == '0) begin
          left <= left - LENW'(1);
          if (left == LENW'(1)) begin
            st <= S_IDLE;
            done <= 1'b1;
          end else if (pidx == 2'd3) begin
            st <= S_FETCH;
          end else begin
            pidx <= nxt;
            tms_q[sel_q] <= shreg[{nxt, 1'b1}];
            tdi_q[sel_q] <= shreg[{nxt, 1'b0}];
            cnt <= dly_q;
            st <= S_LOW;
          end
        end else cnt <= cnt - DLYW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NCHAINS; i++) begin : g_pin
    assign tck_l[i] = (st == S_HIGH) && (sel_q == CHW'(i));
    assign tck_o[i] = tck_l[i] ^ invert[0];
    assign tms_o[i] = tms_q[i] ^ invert[1];
    assign tdi_o[i] = tdi_q[i] ^ invert[2];

    assert_other_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && sel_q != CHW'(i)) |-> ($stable(tms_q[i]) && $stable(tdi_q[i]) && !tck_l[i]));
  end

  st_t             st_d;
  logic [DLYW:0]   run_q;
  wire  [DLYW:0]   run = (st == st_d) ? run_q + 1'b1 : (DLYW+1)'(1);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_d <= S_IDLE;
      run_q <= '0;
    end else begin
      st_d <= st;
      run_q <= run;
    end
  end

  assert_pins_still_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && $past(st == S_HIGH)) |-> ($stable(tms_q) && $stable(tdi_q)));

  assert_high_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_d == S_HIGH && st != S_HIGH) |-> (run_q == {1'b0, dly_q} + 1'b1));

  assert_low_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_d == S_LOW && st != S_LOW) |-> (run_q == {1'b0, dly_q} + 1'b1));

  assert_out_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (st == S_HIGH && $past(st == S_LOW)));

  assert_no_out_uncaptured_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cap_q);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && tck_l == '0) ##1 !done);

endmodule

// File: tb/jtag_pair_shifter_test.sv
`timescale 1ns/1ps
module jtag_pair_shifter_test;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic start = 0, capture = 0, in_valid = 0;
  logic [11:0] pair_count = 0;
  logic [2:0] chain_sel = 0, invert = 0;
  logic [15:0] tck_delay = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, busy, done;
  logic [7:0] out_data;
  logic [N-1:0] tck_o, tms_o, tdi_o, tdo_i;

  jtag_pair_shifter uut (.clk(clk), .rst_n(rst_n), .start(start), .pair_count(pair_count),
    .capture(capture), .chain_sel(chain_sel), .tck_delay(tck_delay), .invert(invert),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .busy(busy), .done(done), .tck_o(tck_o), .tms_o(tms_o),
    .tdi_o(tdi_o), .tdo_i(tdo_i));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] pay [0:1023];
  logic pat [0:4096];
  logic [7:0] got [0:1023];

  int n_cur = 0, d_cur = 0, sel_cur = 0, ncap = 0, nrise = 0, feed_idx = 0, nbytes = 0;
  int hi_len = 0, lo_len = 0, pair_err = 0, hi_err = 0, lo_err = 0, stab_err = 0;
  int other_err = 0, done_cnt = 0, done_err = 0;
  bit mon_on = 0, feed_on = 0, took = 0, prev_t = 0, prev_m = 0, prev_d = 0;
  logic [N-1:0] snap_tck, snap_tms, snap_tdi;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bit(int k, bit tms);
    return pay[k >> 2][2 * (k & 3) + (tms ? 1 : 0)];
  endfunction

  always @(negedge clk) begin
    if (took) feed_idx++;
    in_valid = feed_on && (feed_idx < nbytes) && ($urandom % 4 != 0);
    in_data = (feed_idx < nbytes) ? pay[feed_idx] : 8'h00;
    took = in_ready && in_valid;
  end

  always @(negedge clk) begin
    if (mon_on) begin
      bit t, m, d;
      t = tck_o[sel_cur] ^ invert[0];
      m = tms_o[sel_cur] ^ invert[1];
      d = tdi_o[sel_cur] ^ invert[2];
      if (t && !prev_t) begin
        if (nrise >= n_cur || m != exp_bit(nrise, 1) || d != exp_bit(nrise, 0)) pair_err++;
        if (lo_len < d_cur + 1) lo_err++;
        nrise++;
        hi_len = 1;
      end else if (t) begin
        hi_len++;
        if (m != prev_m || d != prev_d) stab_err++;
      end else if (prev_t) begin
        if (hi_len != d_cur + 1) hi_err++;
        lo_len = 1;
      end else lo_len++;
      for (int i = 0; i < N; i++)
        if (i != sel_cur && (tck_o[i] != snap_tck[i] || tms_o[i] != snap_tms[i] || tdi_o[i] != snap_tdi[i]))
          other_err++;
      if (out_valid) begin
        if (ncap < 1024) got[ncap] = out_data;
        ncap++;
      end
      if (done) begin
        done_cnt++;
        if (t || (n_cur > 0 && !prev_t)) done_err++;
      end
      prev_t = t; prev_m = m; prev_d = d;
      for (int i = 0; i < N; i++) tdo_i[i] = (i == sel_cur) ? pat[nrise] : 1'($urandom);
    end
  end

  task automatic run(int n, bit cap, int sel, int d, bit [2:0] iv, bit restart);
    int limit, nb;
    bit last_m;
    @(negedge clk);
    for (int i = 0; i < (n + 3) / 4; i++) pay[i] = 8'($urandom);
    for (int i = 0; i <= n; i++) pat[i] = 1'($urandom);
    invert = iv;
    @(negedge clk);
    n_cur = n; d_cur = d; sel_cur = sel; ncap = 0; nrise = 0;
    pair_err = 0; hi_err = 0; lo_err = 0; stab_err = 0; other_err = 0;
    done_cnt = 0; done_err = 0; hi_len = 0; lo_len = 0; prev_t = 0;
    snap_tck = tck_o; snap_tms = tms_o; snap_tdi = tdi_o;
    feed_idx = 0; took = 0; nbytes = (n + 3) / 4; feed_on = 1;
    pair_count = 12'(n); capture = cap; chain_sel = 3'(sel); tck_delay = 16'(d);
    for (int i = 0; i < N; i++) tdo_i[i] = (i == sel) ? pat[0] : 1'($urandom);
    prev_m = tms_o[sel] ^ iv[1]; prev_d = tdi_o[sel] ^ iv[2];
    mon_on = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    limit = n * 2 * (d + 1) * 4 + 100;
    for (int c = 0; c < limit && !done; c++) begin
      if (restart && c == 3) begin
        start = 1; pair_count = 5; chain_sel = 3'((sel + 1) % N); capture = !cap;
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk(done == 1'b1, "R9", "done seen", done, 1);
    repeat (restart ? 20 : 3) @(negedge clk);
    mon_on = 0; feed_on = 0;
    chk(nrise == n, "R1", "rising edges", nrise, n);
    chk(pair_err == 0, "R1", "pair order mismatches", pair_err, 0);
    chk(feed_idx == (n + 3) / 4, "R1", "bytes taken", feed_idx, (n + 3) / 4);
    chk(stab_err == 0, "R2", "pin change while TCK high", stab_err, 0);
    chk(hi_err == 0 && lo_err == 0, "R3", "phase length errors", hi_err + lo_err, 0);
    chk(other_err == 0, "R4", "unselected chain changes", other_err, 0);
    chk(done_cnt == 1 && done_err == 0, "R9", "done pulses/misplaced", done_cnt * 10 + done_err, 10);
    chk(tck_o == {N{iv[0]}}, "R5", "idle TCK pins", tck_o, {N{iv[0]}});
    if (n > 0) begin
      last_m = exp_bit(n - 1, 1);
      chk(tms_o[sel] == (last_m ^ iv[1]), "R5", "held TMS pin", tms_o[sel], last_m ^ iv[1]);
    end
    nb = cap ? (n + 7) / 8 : 0;
    if (!cap) chk(ncap == 0, "R8", "bytes out without capture", ncap, 0);
    else begin
      chk(ncap == nb, "R7", "captured byte count", ncap, nb);
      for (int j = 0; j < nb && j < ncap; j++) begin
        logic [7:0] e;
        e = 8'h00;
        for (int b = 0; b < 8; b++) if (8 * j + b < n) e[b] = pat[8 * j + b];
        chk(got[j] == e, (j == nb - 1 && n % 8 != 0) ? "R7" : "R6", "captured byte", got[j], e);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    tdo_i = '0;
    repeat (3) @(negedge clk);
    chk(tck_o == 0 && tms_o == 0 && tdi_o == 0, "R11", "pins in reset", {tck_o, tms_o, tdi_o}, 0);
    chk(!in_ready && !out_valid && !busy && !done, "R11", "flags in reset",
        {in_ready, out_valid, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && tck_o == 0, "R11", "idle after reset", {busy, tck_o}, 0);

    @(negedge clk);
    pair_count = 0; capture = 1; chain_sel = 2; start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1'b1, "R10", "done after zero-length start", done, 1);
    chk(!in_ready && tck_o == 0, "R10", "no byte, no TCK", {in_ready, tck_o}, 0);
    @(negedge clk);
    chk(!done && !busy, "R10", "single done, idle", {done, busy}, 0);

    run(1, 1, 0, 0, 3'b000, 0);
    run(4, 1, 3, 1, 3'b000, 0);
    run(8, 1, 7, 0, 3'b111, 0);
    run(9, 1, 5, 2, 3'b101, 0);
    run(13, 0, 1, 5, 3'b010, 0);
    run(12, 1, 6, 1, 3'b001, 1);
    run(4095, 1, 4, 0, 3'b100, 0);
    for (int r = 0; r < 25; r++)
      run(1 + $urandom % 40, 1'($urandom), $urandom % N, $urandom % 4, 3'($urandom), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule